// File: doc/BRIEF.md
# Deferred-Invalidation MSI Cache Controller

This block keeps the coherence state of a small direct-mapped set of cache lines on a snooping bus. It uses a write-back MSI protocol. Each line holds a state (I, S or M), a tag, one data value and a pending-invalidation flag. The CPU side presents one read or write per cycle. The controller answers hit or miss, and for a miss it raises a bus request: BusRd for reads, BusRdX for writes. A snoop port carries the bus requests of other caches.

The block departs from plain MSI in how it handles a snooped BusRdX that lands on a Shared line. It does not drop the line at once. It marks the line as pending and leaves it Shared, so local reads keep hitting on the old copy. The first local miss of any kind applies every pending invalidation before the missing line is fetched. The pending set is bounded: once it reaches its depth, all entries are applied at once. Two mode inputs select the behaviour. One switches the deferral for Shared lines on or off; with it off, the controller is standard MSI. The other lets a Modified line that snoops BusRdX drop to Shared with a pending invalidation, instead of going straight to Invalid.

Top module: `msi_dq_ctrl`

## Requirements
- R1: Synchronous active-low reset invalidates every line and clears every pending flag. After reset, rsp_valid, bus_req_valid, wb_valid and snp_supply are all 0.
- R2: A request sampled at a clock edge is answered in the registered outputs after that edge. A read hits when the line at index addr[IDX_W-1:0] is S or M with tag addr[ADDR_W-1:IDX_W]. A read hit returns the stored value with rsp_hit=1 and no bus request. A read miss returns fill_data, installs the line as S and raises bus_req_valid with bus_req_excl=0 (BusRd).
- R3: A write hits only on a matching M line: the value is updated and no bus request is made. A write to an I or S line is a miss: it raises bus_req_valid with bus_req_excl=1 (BusRdX) and the line becomes M holding cpu_wdata.
- R4: With defer_shared_en=1, a snooped BusRdX (snp_excl=1) on a matching S line leaves it S and marks it pending. Later local reads of it hit and return the old value.
- R5: With defer_shared_en=0, a snooped BusRdX on a matching S line makes it I at once.
- R6: Any local miss first turns every pending line to I and empties the pending set. Only then is the missing line installed.
- R7: A local write to a pending line is a miss. It issues BusRdX and applies all pending invalidations.
- R8: When the number of pending lines reaches QUEUE_DEPTH, all of them are invalidated in the same cycle.
- R9: A matching M line that snoops BusRd (snp_excl=0) asserts snp_supply with its value on the next cycle and becomes S.
- R10: A matching M line that snoops BusRdX supplies its value. It then goes to I when defer_dirty_en=0, or to S with a pending invalidation when defer_dirty_en=1.
- R11: A miss that replaces an M line holding a different tag raises wb_valid in the same cycle as the bus request. wb_addr and wb_data carry the old line's address and value.
- R12: Two controllers are linked so that each snoops the other's bus requests. The trace "P2 read A, P1 write A, P2 read A, P1 write A, P2 read A, P2 read B, P2 read A" then costs 2 write misses plus 4 read misses in standard mode. With deferral of Shared lines it costs 1 write miss plus 3 read misses.
- R13: When a snoop and a CPU request arrive in the same cycle, the snoop is applied first. The CPU request is looked up against the state the snoop leaves behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| defer_shared_en | input | 1 | Defer invalidation of S lines on snooped BusRdX |
| defer_dirty_en | input | 1 | M line snooping BusRdX drops to S with a pending invalidation |
| cpu_valid | input | 1 | CPU request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU address; low IDX_W bits index, upper bits tag |
| cpu_wdata | input | DATA_W | Write value |
| fill_data | input | DATA_W | Value installed on a read miss |
| snp_valid | input | 1 | Snooped bus request present |
| snp_excl | input | 1 | 1 = BusRdX, 0 = BusRd |
| snp_addr | input | ADDR_W | Snooped address |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_rdata | output | DATA_W | Line value after the access |
| bus_req_valid | output | 1 | Miss request to the bus |
| bus_req_excl | output | 1 | 1 = BusRdX, 0 = BusRd |
| bus_req_addr | output | ADDR_W | Missed address |
| wb_valid | output | 1 | Dirty line written back |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Value of the written-back line |
| snp_supply | output | 1 | This cache supplies data for the snooped request |
| snp_data | output | DATA_W | Supplied value |

## Verification
Response, bus request and write-back for a CPU request sampled at edge N are all due in the registered outputs after edge N. Supply for a snoop sampled at edge N is due at the same point. Because two controllers are wired to snoop each other, the peer's supply follows the originating request by one more cycle. The bench steps a behavioural model of both caches once per clock with the same inputs. It compares every output at the falling edge after each rising edge, so each result is checked in exactly the cycle it is due. The pending state is observed only through later hits and misses.

// File: rtl/msi_dq_pkg.sv
// Shared types for the deferred-invalidation MSI controller.
// Assumes a two-bit encoding is enough for the three stable MSI states.
package msi_dq_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_state_e;

endpackage

// File: rtl/msi_dq_snoop_slice.sv
// Per-line snoop reaction. Given one line's state, tag and pending flag and
// the current snoop, it gives the line's next state and pending flag and
// says whether the line must supply data.
// Assumes the caller has already gated the snoop with the index match.
module msi_dq_snoop_slice
    import msi_dq_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             sel_i,
    input  logic             excl_i,
    input  logic [TAG_W-1:0] snp_tag_i,
    input  logic [TAG_W-1:0] line_tag_i,
    input  logic             defer_shared_i,
    input  logic             defer_dirty_i,
    input  line_state_e      st_i,
    input  logic             pend_i,
    output line_state_e      st_o,
    output logic             pend_o,
    output logic             supply_o
);

    logic match;

    // Decide the snoop outcome for this line.
    always_comb begin
        match    = sel_i && (st_i != LN_I) && (line_tag_i == snp_tag_i);
        st_o     = st_i;
        pend_o   = pend_i;
        supply_o = 1'b0;
        if (match) begin
            case (st_i)
                LN_M: begin
                    supply_o = 1'b1;
                    if (!excl_i) begin
                        st_o = LN_S;
                    end else if (defer_dirty_i) begin
                        st_o   = LN_S;
                        pend_o = 1'b1;
                    end else begin
                        st_o = LN_I;
                    end
                end
                LN_S: begin
                    if (excl_i) begin
                        if (defer_shared_i) begin
                            pend_o = 1'b1;
                        end else begin
                            st_o   = LN_I;
                            pend_o = 1'b0;
                        end
                    end
                end
                default: begin
                    st_o = st_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/msi_dq_drain.sv
// Applies pending invalidations. Every pending line goes to I and the
// pending set is cleared, either on request (a local miss) or when the
// pending set has reached QUEUE_DEPTH.
// Assumes pending lines are always Shared.
module msi_dq_drain
    import msi_dq_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int QUEUE_DEPTH = 2
) (
    input  logic                 force_i,
    input  line_state_e          st_i   [NUM_LINES],
    input  logic [NUM_LINES-1:0] pend_i,
    output line_state_e          st_o   [NUM_LINES],
    output logic [NUM_LINES-1:0] pend_o,
    output logic                 drained_o
);

    logic full;

    // Trigger a drain on request or when the set is at depth.
    always_comb begin
        full      = $countones(pend_i) >= QUEUE_DEPTH;
        drained_o = force_i || full;
    end

    // Clear the pending lines when a drain fires.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            always_comb begin
                st_o[g]   = (drained_o && pend_i[g]) ? LN_I : st_i[g];
                pend_o[g] = drained_o ? 1'b0 : pend_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/msi_dq_lookup.sv
// CPU-side hit test for one indexed line. A read hits on S or M with a
// matching tag. A write hits only on M with a matching tag.
// Assumes the state given is the one left after snoop and full-drain.
module msi_dq_lookup
    import msi_dq_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             valid_i,
    input  logic             write_i,
    input  line_state_e      st_i,
    input  logic [TAG_W-1:0] line_tag_i,
    input  logic [TAG_W-1:0] req_tag_i,
    output logic             hit_o,
    output logic             miss_o
);

    logic present;

    // Classify the request as hit or miss.
    always_comb begin
        present = (st_i != LN_I) && (line_tag_i == req_tag_i);
        hit_o   = valid_i && present && (!write_i || (st_i == LN_M));
        miss_o  = valid_i && !hit_o;
    end

endmodule

// File: rtl/msi_dq_ctrl.sv
// Snooping write-back MSI controller with deferred invalidation.
// Each cycle: (1) the snoop is applied to all lines, (2) a full pending set
// is drained, (3) the CPU request is looked up, (4) a miss drains all
// pending lines and installs the new line. All results are registered and
// appear after the edge that sampled the inputs.
// Assumes NUM_LINES is a power of two and QUEUE_DEPTH <= NUM_LINES.
module msi_dq_ctrl
    import msi_dq_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int QUEUE_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              defer_shared_en,
    input  logic              defer_dirty_en,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req_valid,
    output logic              bus_req_excl,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_state_e          st_q   [NUM_LINES];
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [DATA_W-1:0]    val_q  [NUM_LINES];
    logic [NUM_LINES-1:0] pend_q;

    line_state_e          st_a   [NUM_LINES];
    line_state_e          st_b   [NUM_LINES];
    line_state_e          st_c   [NUM_LINES];
    line_state_e          st_n   [NUM_LINES];
    logic [TAG_W-1:0]     tag_n  [NUM_LINES];
    logic [DATA_W-1:0]    val_n  [NUM_LINES];
    logic [NUM_LINES-1:0] pend_a;
    logic [NUM_LINES-1:0] pend_b;
    logic [NUM_LINES-1:0] pend_c;
    logic [NUM_LINES-1:0] sup_vec;
    logic                 full_drain;
    logic                 miss_drain;

    logic [IDX_W-1:0]     cpu_idx;
    logic [TAG_W-1:0]     cpu_tag;
    logic [IDX_W-1:0]     snp_idx;
    logic [TAG_W-1:0]     snp_tag;
    line_state_e          st_b_sel;
    line_state_e          st_c_sel;
    logic                 cpu_hit;
    logic                 cpu_miss;
    logic                 evict;

    // Split the CPU and snoop addresses into index and tag.
    always_comb begin
        cpu_idx = cpu_addr[IDX_W-1:0];
        cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
        snp_idx = snp_addr[IDX_W-1:0];
        snp_tag = snp_addr[ADDR_W-1:IDX_W];
    end

    // Stage 1: snoop reaction, one slice per line.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_snoop
            msi_dq_snoop_slice #(.TAG_W(TAG_W)) u_slice (
                .sel_i         (snp_valid && (snp_idx == IDX_W'(g))),
                .excl_i        (snp_excl),
                .snp_tag_i     (snp_tag),
                .line_tag_i    (tag_q[g]),
                .defer_shared_i(defer_shared_en),
                .defer_dirty_i (defer_dirty_en),
                .st_i          (st_q[g]),
                .pend_i        (pend_q[g]),
                .st_o          (st_a[g]),
                .pend_o        (pend_a[g]),
                .supply_o      (sup_vec[g])
            );
        end
    endgenerate

    // Stage 2: drain when the pending set has reached its depth.
    msi_dq_drain #(.NUM_LINES(NUM_LINES), .QUEUE_DEPTH(QUEUE_DEPTH)) u_drain_full (
        .force_i  (1'b0),
        .st_i     (st_a),
        .pend_i   (pend_a),
        .st_o     (st_b),
        .pend_o   (pend_b),
        .drained_o(full_drain)
    );

    // Select the indexed line state for lookup and eviction.
    always_comb begin
        st_b_sel = st_b[cpu_idx];
        st_c_sel = st_c[cpu_idx];
    end

    // Stage 3: CPU hit test against the post-snoop state.
    msi_dq_lookup #(.TAG_W(TAG_W)) u_lookup (
        .valid_i   (cpu_valid),
        .write_i   (cpu_write),
        .st_i      (st_b_sel),
        .line_tag_i(tag_q[cpu_idx]),
        .req_tag_i (cpu_tag),
        .hit_o     (cpu_hit),
        .miss_o    (cpu_miss)
    );

    // Stage 4: a local miss applies every pending invalidation.
    msi_dq_drain #(.NUM_LINES(NUM_LINES), .QUEUE_DEPTH(QUEUE_DEPTH)) u_drain_miss (
        .force_i  (cpu_miss),
        .st_i     (st_b),
        .pend_i   (pend_b),
        .st_o     (st_c),
        .pend_o   (pend_c),
        .drained_o(miss_drain)
    );

    // A dirty line with another tag must be written back on a miss.
    always_comb begin
        evict = cpu_miss && (st_c_sel == LN_M) && (tag_q[cpu_idx] != cpu_tag);
    end

    // Build the next line arrays, including the install or write update.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            st_n[i]  = st_c[i];
            tag_n[i] = tag_q[i];
            val_n[i] = val_q[i];
        end
        if (cpu_miss) begin
            st_n[cpu_idx]  = cpu_write ? LN_M : LN_S;
            tag_n[cpu_idx] = cpu_tag;
            val_n[cpu_idx] = cpu_write ? cpu_wdata : fill_data;
        end else if (cpu_hit && cpu_write) begin
            val_n[cpu_idx] = cpu_wdata;
        end
    end

    // Line state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i]  <= LN_I;
                tag_q[i] <= '0;
                val_q[i] <= '0;
            end
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i]  <= st_n[i];
                tag_q[i] <= tag_n[i];
                val_q[i] <= val_n[i];
            end
            pend_q <= pend_c;
        end
    end

    // Registered response, bus request, write-back and snoop supply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_rdata     <= '0;
            bus_req_valid <= 1'b0;
            bus_req_excl  <= 1'b0;
            bus_req_addr  <= '0;
            wb_valid      <= 1'b0;
            wb_addr       <= '0;
            wb_data       <= '0;
            snp_supply    <= 1'b0;
            snp_data      <= '0;
        end else begin
            rsp_valid     <= cpu_valid;
            rsp_hit       <= cpu_hit;
            rsp_rdata     <= val_n[cpu_idx];
            bus_req_valid <= cpu_miss;
            bus_req_excl  <= cpu_write;
            bus_req_addr  <= cpu_addr;
            wb_valid      <= evict;
            wb_addr       <= {tag_q[cpu_idx], cpu_idx};
            wb_data       <= val_q[cpu_idx];
            snp_supply    <= |sup_vec;
            snp_data      <= val_q[snp_idx];
        end
    end

    // Pending lines must be Shared.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_pend_chk
            AST_PEND_IS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
                pend_q[g] |-> (st_q[g] == LN_S)); // R4
        end
    endgenerate

    AST_QUEUE_BELOW_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_q) < QUEUE_DEPTH); // R8

    AST_MISS_EMPTIES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (pend_q == '0)); // R6

    AST_HIT_SILENT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !bus_req_valid); // R2

    AST_WB_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (bus_req_valid && rsp_valid && !rsp_hit)); // R11

    AST_DIRTY_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (st_q[snp_idx] == LN_M) && (tag_q[snp_idx] == snp_tag))
        |=> snp_supply); // R9

    AST_WRITE_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_write && !cpu_hit) |=> (bus_req_valid && bus_req_excl)); // R3

endmodule

// File: tb/msi_dq_ctrl_bench.sv
// Two linked controllers (index 0 = P1, index 1 = P2), each snooping the
// other's bus request. A behavioural model of both is stepped every clock
// and every output is compared at the falling edge.
module msi_dq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int QD = 2;
    localparam int ST_I = 0;
    localparam int ST_S = 1;
    localparam int ST_M = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dse = 1'b1;
    logic dde = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]    cv, cw;
    logic [AW-1:0] ca  [2];
    logic [DW-1:0] cwd [2];
    logic [DW-1:0] fil [2];

    logic [1:0]    rv, rh, bv, bx, wv, sup;
    logic [DW-1:0] rd [2];
    logic [DW-1:0] wd [2];
    logic [DW-1:0] sd [2];
    logic [AW-1:0] ba [2];
    logic [AW-1:0] wa [2];

    msi_dq_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW), .QUEUE_DEPTH(QD)) u_msi_dq_ctrl (
        .clk(clk), .rst_n(rst_n), .defer_shared_en(dse), .defer_dirty_en(dde),
        .cpu_valid(cv[0]), .cpu_write(cw[0]), .cpu_addr(ca[0]), .cpu_wdata(cwd[0]),
        .fill_data(fil[0]), .snp_valid(bv[1]), .snp_excl(bx[1]), .snp_addr(ba[1]),
        .rsp_valid(rv[0]), .rsp_hit(rh[0]), .rsp_rdata(rd[0]),
        .bus_req_valid(bv[0]), .bus_req_excl(bx[0]), .bus_req_addr(ba[0]),
        .wb_valid(wv[0]), .wb_addr(wa[0]), .wb_data(wd[0]),
        .snp_supply(sup[0]), .snp_data(sd[0])
    );

    msi_dq_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW), .QUEUE_DEPTH(QD)) u_msi_dq_ctrl_peer (
        .clk(clk), .rst_n(rst_n), .defer_shared_en(dse), .defer_dirty_en(dde),
        .cpu_valid(cv[1]), .cpu_write(cw[1]), .cpu_addr(ca[1]), .cpu_wdata(cwd[1]),
        .fill_data(fil[1]), .snp_valid(bv[0]), .snp_excl(bx[0]), .snp_addr(ba[0]),
        .rsp_valid(rv[1]), .rsp_hit(rh[1]), .rsp_rdata(rd[1]),
        .bus_req_valid(bv[1]), .bus_req_excl(bx[1]), .bus_req_addr(ba[1]),
        .wb_valid(wv[1]), .wb_addr(wa[1]), .wb_data(wd[1]),
        .snp_supply(sup[1]), .snp_data(sd[1])
    );

    int m_st   [2][NL];
    int m_tag  [2][NL];
    int m_val  [2][NL];
    bit m_pend [2][NL];
    bit e_rv[2], e_rh[2], e_bv[2], e_bx[2], e_wv[2], e_sup[2];
    int e_rd[2], e_ba[2], e_wa[2], e_wd[2], e_sd[2];

    int    n_cmp = 0;
    int    n_bad = 0;
    int    miss_cnt [2];
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic chk(string req, string what, logic [31:0] act, int exp);
        n_cmp++;
        if (act !== exp[31:0]) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < 2; c++) begin
            chk(cur_req, "rsp_valid", 32'(rv[c]), int'(e_rv[c]));
            if (e_rv[c]) begin
                chk(cur_req, "rsp_hit", 32'(rh[c]), int'(e_rh[c]));
                chk(cur_req, "rsp_rdata", 32'(rd[c]), e_rd[c]);
            end
            chk(cur_req, "bus_req_valid", 32'(bv[c]), int'(e_bv[c]));
            if (e_bv[c]) begin
                chk(cur_req, "bus_req_excl", 32'(bx[c]), int'(e_bx[c]));
                chk(cur_req, "bus_req_addr", 32'(ba[c]), e_ba[c]);
            end
            chk(cur_req, "wb_valid", 32'(wv[c]), int'(e_wv[c]));
            if (e_wv[c]) begin
                chk(cur_req, "wb_addr", 32'(wa[c]), e_wa[c]);
                chk(cur_req, "wb_data", 32'(wd[c]), e_wd[c]);
            end
            chk(cur_req, "snp_supply", 32'(sup[c]), int'(e_sup[c]));
            if (e_sup[c]) chk(cur_req, "snp_data", 32'(sd[c]), e_sd[c]);
            if (rv[c] === 1'b1 && rh[c] === 1'b0) miss_cnt[c]++;
        end
    endtask

    task automatic drain_model(int c);
        for (int i = 0; i < NL; i++) begin
            if (m_pend[c][i]) m_st[c][i] = ST_I;
            m_pend[c][i] = 1'b0;
        end
    endtask

    // Behavioural reference for one cache: snoop, full drain, CPU access.
    task automatic model_step(int c, bit sv, bit sx, int sa);
        int si, stg, ci, ctg, cnt;
        bit hit;
        e_rv[c] = 0; e_rh[c] = 0; e_bv[c] = 0; e_wv[c] = 0; e_sup[c] = 0;
        if (sv) begin
            si = sa % NL; stg = sa / NL;
            if (m_st[c][si] != ST_I && m_tag[c][si] == stg) begin
                if (m_st[c][si] == ST_M) begin
                    e_sup[c] = 1; e_sd[c] = m_val[c][si];
                    if (!sx) m_st[c][si] = ST_S;
                    else if (dde) begin m_st[c][si] = ST_S; m_pend[c][si] = 1; end
                    else m_st[c][si] = ST_I;
                end else if (sx) begin
                    if (dse) m_pend[c][si] = 1;
                    else begin m_st[c][si] = ST_I; m_pend[c][si] = 0; end
                end
            end
        end
        cnt = 0;
        for (int i = 0; i < NL; i++) cnt += int'(m_pend[c][i]);
        if (cnt >= QD) drain_model(c);
        if (cv[c]) begin
            ci = int'(ca[c]) % NL; ctg = int'(ca[c]) / NL;
            if (cw[c]) hit = (m_st[c][ci] == ST_M) && (m_tag[c][ci] == ctg);
            else       hit = (m_st[c][ci] != ST_I) && (m_tag[c][ci] == ctg);
            e_rv[c] = 1; e_rh[c] = hit;
            if (hit) begin
                if (cw[c]) m_val[c][ci] = int'(cwd[c]);
            end else begin
                drain_model(c);
                if (m_st[c][ci] == ST_M && m_tag[c][ci] != ctg) begin
                    e_wv[c] = 1; e_wa[c] = m_tag[c][ci] * NL + ci; e_wd[c] = m_val[c][ci];
                end
                e_bv[c] = 1; e_bx[c] = cw[c]; e_ba[c] = int'(ca[c]);
                m_tag[c][ci] = ctg;
                m_st[c][ci]  = cw[c] ? ST_M : ST_S;
                m_val[c][ci] = cw[c] ? int'(cwd[c]) : int'(fil[c]);
            end
            e_rd[c] = m_val[c][ci];
        end
    endtask

    task automatic tick();
        bit pv[2], px[2];
        int pa[2];
        for (int c = 0; c < 2; c++) begin pv[c] = e_bv[c]; px[c] = e_bx[c]; pa[c] = e_ba[c]; end
        model_step(0, pv[1], px[1], pa[1]);
        model_step(1, pv[0], px[0], pa[0]);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        cv = '0; cw = '0;
        for (int c = 0; c < 2; c++) begin ca[c] = '0; cwd[c] = '0; fil[c] = '0; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NL; i++) begin
                m_st[c][i] = ST_I; m_tag[c][i] = 0; m_val[c][i] = 0; m_pend[c][i] = 0;
            end
            e_rv[c] = 0; e_bv[c] = 0; e_wv[c] = 0; e_sup[c] = 0; e_ba[c] = 0; e_bx[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin
            chk("R1", "rsp_valid after reset", 32'(rv[c]), 0);
            chk("R1", "bus_req_valid after reset", 32'(bv[c]), 0);
            chk("R1", "wb_valid after reset", 32'(wv[c]), 0);
            chk("R1", "snp_supply after reset", 32'(sup[c]), 0);
            miss_cnt[c] = 0;
        end
    endtask

    // One CPU access on cache c followed by two quiet cycles.
    task automatic op(int c, bit w, int a, int d);
        cv[c] = 1'b1; cw[c] = w; ca[c] = AW'(a); cwd[c] = DW'(d); fil[c] = DW'(d ^ 16'h5a5a);
        tick();
        cv[c] = 1'b0;
        tick();
        tick();
    endtask

    task automatic run_trace(bit shared_defer, int exp_p1, int exp_p2);
        dse = shared_defer; dde = 1'b0;
        do_reset();
        cur_req = "R12";
        op(1, 0, 5, 16'h0101);
        op(0, 1, 5, 16'h0a0a);
        op(1, 0, 5, 16'h0202);
        op(0, 1, 5, 16'h0b0b);
        op(1, 0, 5, 16'h0303);
        op(1, 0, 6, 16'h0404);
        op(1, 0, 5, 16'h0505);
        chk("R12", "P1 miss count", 32'(miss_cnt[0]), exp_p1);
        chk("R12", "P2 miss count", 32'(miss_cnt[1]), exp_p2);
    endtask

    initial begin
        void'($urandom(7));
        idle_inputs();

        // R2 and R3: basic read and write behaviour on one cache.
        dse = 1; dde = 0; do_reset();
        cur_req = "R2"; op(0, 0, 5, 16'h1111); op(0, 0, 5, 16'h2222);
        cur_req = "R3"; op(0, 1, 5, 16'h3333); op(0, 1, 5, 16'h4444); op(0, 0, 5, 16'h0);

        // R4 then R6: deferred line hits stale, then a miss drains it.
        do_reset();
        cur_req = "R4"; op(1, 0, 5, 16'h1234); op(0, 1, 5, 16'h9999); op(1, 0, 5, 16'h0);
        cur_req = "R6"; op(1, 0, 6, 16'h4321); op(1, 0, 5, 16'h7777);

        // R7: write to a pending line is a miss; peer M supplies and goes to I.
        do_reset();
        cur_req = "R7"; op(1, 0, 5, 16'h0011); op(0, 1, 5, 16'h0022); op(1, 1, 5, 16'h0033);
        op(0, 0, 5, 16'h0044);

        // R8: two pending lines reach the depth and drain at once.
        do_reset();
        cur_req = "R8"; op(1, 0, 4, 16'h0100); op(1, 0, 5, 16'h0200);
        op(0, 1, 4, 16'h0300); op(0, 1, 5, 16'h0400); op(1, 0, 4, 16'h0500);

        // R5: no deferral, S line dropped at the snoop.
        dse = 0; do_reset();
        cur_req = "R5"; op(1, 0, 5, 16'h5000); op(0, 1, 5, 16'h5100); op(1, 0, 5, 16'h5200);

        // R9: M line snooping BusRd supplies and drops to S.
        dse = 1; do_reset();
        cur_req = "R9"; op(0, 1, 5, 16'h6000); op(1, 0, 5, 16'h6100);
        op(0, 0, 5, 16'h0); op(0, 1, 5, 16'h6200);

        // R10: M line snooping BusRdX with dirty deferral goes to S pending.
        dde = 1; do_reset();
        cur_req = "R10"; op(0, 1, 5, 16'h7000); op(1, 1, 5, 16'h7100); op(0, 0, 5, 16'h0);
        op(0, 0, 6, 16'h7200); op(0, 0, 5, 16'h7300);
        dde = 0;

        // R11: replacing a dirty line with another tag writes it back.
        do_reset();
        cur_req = "R11"; op(0, 1, 5, 16'h8000); op(0, 1, 9, 16'h8100); op(0, 0, 13, 16'h8200);

        // R13: snoop and CPU request in the same cycle; snoop wins.
        dse = 0; do_reset();
        cur_req = "R13"; op(1, 0, 5, 16'h9000);
        cv[0] = 1; cw[0] = 1; ca[0] = 6'd5; cwd[0] = 16'h9100; tick();
        cv[0] = 0; cv[1] = 1; cw[1] = 0; ca[1] = 6'd5; fil[1] = 16'h9200; tick();
        cv[1] = 0; tick(); tick();

        // R12: miss counts for the two-cache trace in both modes.
        run_trace(1'b0, 2, 4);
        run_trace(1'b1, 1, 3);

        // R13: random mixed traffic on both caches, model compared each cycle.
        do_reset();
        cur_req = "R13";
        for (int n = 0; n < 800; n++) begin
            if (n % 200 == 0) begin dse = 1'($urandom_range(0, 1)); dde = 1'($urandom_range(0, 1)); end
            for (int c = 0; c < 2; c++) begin
                cv[c] = 1'($urandom_range(0, 1));
                cw[c] = 1'($urandom_range(0, 1));
                ca[c] = AW'($urandom_range(0, 11));
                cwd[c] = DW'($urandom);
                fil[c] = DW'($urandom);
            end
            tick();
        end
        idle_inputs();
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule